// File: doc/BRIEF.md
# UART Transmitter with Holding Register and Completion Flags

This block serializes bytes onto a single UART line. Software-side logic writes a byte into a one-entry holding register. On a baud tick the byte moves into a shift register, which sends a frame of one low start bit, the data bits least significant bit first, and one high stop bit. Each bit lasts from one baud tick to the next. The baud tick comes from outside the block.

Two status flags describe the transmitter. The "holding empty" flag shows that another byte may be written. The "transmission done" flag shows that the last frame has left the line and that no byte is waiting. The done flag has two clear sources: a write-one-to-clear strobe and any write to the holding register. It is also forced high while the transmitter is disabled and the shifter is idle. An interrupt line combines the two flags, each gated by its own enable.

Top module: `uart_txf`

## Requirements
- R1: After reset, hold_empty is 1, tx_done is 1, txd is 1, and irq is 0 when both interrupt enables are 0.
- R2: A cycle with wr_stb high captures wr_data into the holding register. From the next cycle hold_empty is 0.
- R3: A byte is transferred when all of these hold in one cycle: baud_tick is high, tx_en is high, the holding register is full, and the shifter is either idle or ending its stop bit. After that edge txd is 0 (start bit) and hold_empty is 1.
- R4: A frame on txd is 0, then data bit 0 through data bit 7, then 1. Each bit changes only on a baud_tick edge, and txd is 1 whenever no frame is in progress.
- R5: A byte written while a frame is being shifted waits in the holding register. It starts on the same tick that ends the current stop bit, with no idle bit time in between.
- R6: tx_done rises after the tick that ends a stop bit, provided the holding register was empty in that cycle. While a frame is in progress, tx_done stays low.
- R7: A cpl_clr pulse clears tx_done in the next cycle. If a set condition occurs in the same cycle, the set wins.
- R8: A write to the holding register clears tx_done in the next cycle. This takes priority over a frame ending in the same cycle. It does not take priority over the disabled-idle force of R9.
- R9: While tx_en is 0 and no frame is in progress, tx_done is 1 from the next cycle, whatever cpl_clr and wr_stb do.
- R10: With tx_en at 0, no new frame starts and a written byte stays held. A frame already in progress when tx_en falls completes unchanged.
- R11: irq equals (hold_empty AND empty_ie) OR (tx_done AND cpl_ie), updating combinationally with the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cpl_clr | input | 1 | Write-one-to-clear strobe for tx_done |
| empty_ie | input | 1 | Interrupt enable for hold_empty |
| cpl_ie | input | 1 | Interrupt enable for tx_done |
| txd | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission done flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted bit counter or shift register shows on txd at the very next baud tick, as a wrong data bit, a missing stop bit, or a start bit that never ends. A wrong holding-register state shows on hold_empty, and therefore on irq, one cycle after the write or transfer that should have changed it. A wrong priority among the done flag's set and clear sources shows on tx_done one cycle after the cycle in which the sources coincide. The bench therefore checks every bit of a frame for all 256 byte values, with several tick spacings, and it creates each of those coincidences on purpose.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
  localparam int unsigned DEF_DATA_W = 8;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;
endpackage

// File: rtl/uart_txf_rst_sync.sv
module uart_txf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_txf_hold.sv
module uart_txf_hold #(
  parameter int unsigned DATA_W = uart_txf_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  logic              full_d;
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  // Next-state logic: a write takes priority over the drain caused by a transfer.
  always_comb begin
    full_d = full_q;
    if (load)   full_d = 1'b0;
    if (wr_stb) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full_q <= 1'b0;
    else             full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (wr_stb) data_q <= wr_data;
  end

  assign hold_data = data_q;
  assign hold_full = full_q;

  // R2: a write fills the holding register with the written byte
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (hold_full && hold_data == $past(wr_data)));

  // R3: a transfer with no write in the same cycle leaves the register empty
  a_r3_load_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_stb) |=> !hold_full);

  // R10: without a transfer or write the contents are kept
  a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wr_stb) |=> ($stable(hold_full) && $stable(hold_data)));
endmodule

// File: rtl/uart_txf_shift.sv
module uart_txf_shift
  import uart_txf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              busy,
  output logic              last_bit
);
  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  sh_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              txd_q, txd_d;
  logic              adv;

  assign busy     = (state_q == SH_BUSY);
  assign last_bit = (cnt_q == LAST_IDX);
  assign adv      = busy && baud_tick;

  // Next-state logic. The shift register refills with ones, so the stop bit
  // comes out of the register after the last data bit.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    txd_d   = txd_q;
    if (load) begin
      state_d = SH_BUSY;
      cnt_d   = '0;
      sh_d    = load_data;
      txd_d   = 1'b0;
    end else if (adv) begin
      if (last_bit) begin
        state_d = SH_IDLE;
        txd_d   = 1'b1;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
        txd_d   = sh_q[0];
        sh_d    = {1'b1, sh_q[DATA_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '1;
      txd_q   <= 1'b1;
    end else if (load || adv) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      txd_q   <= txd_d;
    end
  end

  assign txd = txd_q;

  // R4: the line is high whenever no frame is in progress
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R4: bits change only on tick edges
  a_r4_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !load) |=> ($stable(txd) && $stable(busy)));

  // R3: a transfer always starts with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!txd && busy));

  // R4: the tick ending the final bit leaves the line high unless reloaded
  a_r4_stop_end: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_bit && !load) |=> (!busy && txd));
endmodule

// File: rtl/uart_txf_flags.sv
module uart_txf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic busy,
  input  logic frame_end,
  input  logic hold_full,
  input  logic wr_stb,
  input  logic cpl_clr,
  input  logic empty_ie,
  input  logic cpl_ie,
  output logic hold_empty,
  output logic tx_done,
  output logic irq
);
  logic done_q, done_d;
  logic set_end, set_idle;

  assign set_end  = frame_end && !hold_full;
  assign set_idle = !tx_en && !busy;

  // Priority, lowest to highest: clear strobe, frame-end set, write, disabled-idle force.
  always_comb begin
    done_d = done_q;
    if (cpl_clr)  done_d = 1'b0;
    if (set_end)  done_d = 1'b1;
    if (wr_stb)   done_d = 1'b0;
    if (set_idle) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b1;
    else        done_q <= done_d;
  end

  assign tx_done    = done_q;
  assign hold_empty = !hold_full;
  assign irq        = (hold_empty && empty_ie) || (tx_done && cpl_ie);

  // R9: disabled and idle forces the done flag
  a_r9_idle_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> tx_done);

  // R7: the clear strobe works when no set condition coincides
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_clr && !(frame_end && !hold_full) && (tx_en || busy)) |=> !tx_done);

  // R8: a write clears the flag unless the disabled-idle force applies
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (tx_en || busy)) |=> !tx_done);

  // R6: a frame ending with nothing waiting sets the flag
  a_r6_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hold_full && !wr_stb) |=> tx_done);

  // R6: the flag never rises in the middle of a frame
  a_r6_no_mid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> !$rose(tx_done));
endmodule

// File: rtl/uart_txf.sv
module uart_txf
  import uart_txf_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpl_clr,
  input  logic              empty_ie,
  input  logic              cpl_ie,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              irq
);
  logic              rst_sync_n;
  logic              load;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              last_bit;
  logic              frame_end;

  uart_txf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // A byte moves only on a tick, so every bit of the frame lasts a full tick period.
  assign frame_end = busy && baud_tick && last_bit;
  assign load      = tx_en && hold_full && baud_tick && (!busy || last_bit);

  uart_txf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .load      (load),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  uart_txf_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .baud_tick (baud_tick),
    .load      (load),
    .load_data (hold_data),
    .txd       (txd),
    .busy      (busy),
    .last_bit  (last_bit)
  );

  uart_txf_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tx_en      (tx_en),
    .busy       (busy),
    .frame_end  (frame_end),
    .hold_full  (hold_full),
    .wr_stb     (wr_stb),
    .cpl_clr    (cpl_clr),
    .empty_ie   (empty_ie),
    .cpl_ie     (cpl_ie),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .irq        (irq)
  );

  // R10: nothing starts while the transmitter is disabled
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_en && !busy) |=> !busy);

  // R5: a waiting byte starts on the tick that ends the stop bit
  a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_end && hold_full && tx_en) |=> (busy && !txd && hold_empty));
endmodule

// File: tb/uart_txf_bench.sv
module uart_txf_bench;
  logic       clk;
  logic       rst_n;
  logic       tx_en;
  logic       baud_tick;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       cpl_clr;
  logic       empty_ie;
  logic       cpl_ie;
  logic       txd;
  logic       hold_empty;
  logic       tx_done;
  logic       irq;

  int checks;
  int errors;
  bit finished;

  uart_txf u_uart_txf (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .baud_tick  (baud_tick),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .cpl_clr    (cpl_clr),
    .empty_ie   (empty_ie),
    .cpl_ie     (cpl_ie),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] b);
    wr_stb  = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // Eight data ticks, each checked against the expected bit (R4).
  task automatic data_bits(input logic [7:0] b, input int gap);
    for (int i = 0; i < 8; i++) begin
      idle(gap);
      if (gap > 0) chk("R4 bit held between ticks", txd, (i == 0) ? 0 : b[i-1]);
      tick();
      chk("R4 data bit", txd, b[i]);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; tx_en = 1'b0; baud_tick = 1'b0; wr_stb = 1'b0;
    wr_data = 8'h00; cpl_clr = 1'b0; empty_ie = 1'b0; cpl_ie = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R1 hold_empty", hold_empty, 1);
    chk("R1 tx_done", tx_done, 1);
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);

    tx_en = 1'b1;
    idle(1);

    // Sweep all byte values with tick spacings 0..2 idle cycles.
    for (int v = 0; v < 256; v++) begin
      int gap;
      logic [7:0] b;
      gap = v % 3;
      b = 8'(v);
      write(b);
      chk("R2 hold_empty after write", hold_empty, 0);
      chk("R8 tx_done after write", tx_done, 0);
      idle(gap);
      chk("R4 idle line", txd, 1);
      tick();
      chk("R3 start bit", txd, 0);
      chk("R3 hold_empty after transfer", hold_empty, 1);
      data_bits(b, gap);
      idle(gap);
      tick();
      chk("R4 stop bit", txd, 1);
      chk("R6 done low during frame", tx_done, 0);
      idle(gap);
      tick();
      chk("R6 done after frame", tx_done, 1);
      chk("R4 idle after frame", txd, 1);
    end

    // R5: back-to-back frames
    write(8'hA5);
    tick();
    chk("R3 start A", txd, 0);
    write(8'h3C);
    chk("R5 byte waits", hold_empty, 0);
    data_bits(8'hA5, 1);
    tick();
    chk("R4 stop A", txd, 1);
    tick();
    chk("R5 start B without gap", txd, 0);
    chk("R5 hold_empty after reload", hold_empty, 1);
    chk("R5 done stays low", tx_done, 0);
    data_bits(8'h3C, 0);
    tick();
    tick();
    chk("R6 done after B", tx_done, 1);

    // R7: plain clear, then clear coinciding with frame end
    cpl_clr = 1'b1; idle(1); cpl_clr = 1'b0;
    chk("R7 clear", tx_done, 0);
    idle(2);
    chk("R7 clear persists", tx_done, 0);
    write(8'h81);
    tick();
    data_bits(8'h81, 0);
    tick();
    cpl_clr = 1'b1;
    tick();
    cpl_clr = 1'b0;
    chk("R7 set wins over clear", tx_done, 1);

    // R8: write coinciding with frame end
    write(8'h5A);
    tick();
    data_bits(8'h5A, 0);
    tick();
    wr_stb = 1'b1; wr_data = 8'hC3;
    tick();
    wr_stb = 1'b0;
    chk("R8 write beats frame end", tx_done, 0);
    chk("R8 byte held", hold_empty, 0);
    chk("R8 line idle", txd, 1);
    tick();
    chk("R3 start C", txd, 0);
    data_bits(8'hC3, 0);
    tick();
    tick();
    chk("R6 done after C", tx_done, 1);

    // R9: disabled-idle force
    cpl_clr = 1'b1; idle(1); cpl_clr = 1'b0;
    chk("R7 clear before disable", tx_done, 0);
    tx_en = 1'b0;
    idle(1);
    chk("R9 forced at once", tx_done, 1);
    cpl_clr = 1'b1; idle(1); cpl_clr = 1'b0;
    chk("R9 clear has no effect", tx_done, 1);
    write(8'h96);
    chk("R9 write does not clear", tx_done, 1);
    chk("R2 byte stored while disabled", hold_empty, 0);

    // R10: no start while disabled; frame in progress completes
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10 no start", txd, 1);
      chk("R10 byte kept", hold_empty, 0);
    end
    tx_en = 1'b1;
    idle(1);
    tick();
    chk("R10 start on enable", txd, 0);
    tx_en = 1'b0;
    data_bits(8'h96, 0);
    tick();
    chk("R10 stop after disable", txd, 1);
    tick();
    chk("R10 idle after frame", txd, 1);
    chk("R10 hold empty", hold_empty, 1);
    chk("R9 done after frame", tx_done, 1);

    // R11: interrupt combinations in three flag states
    tx_en = 1'b1;
    idle(1);
    for (int ie = 0; ie < 4; ie++) begin
      empty_ie = ie[0]; cpl_ie = ie[1];
      #1;
      chk("R11 irq empty=1 done=1", irq, (ie != 0) ? 1 : 0);
    end
    empty_ie = 1'b0; cpl_ie = 1'b0;
    write(8'h11);
    for (int ie = 0; ie < 4; ie++) begin
      empty_ie = ie[0]; cpl_ie = ie[1];
      #1;
      chk("R11 irq empty=0 done=0", irq, 0);
    end
    empty_ie = 1'b0; cpl_ie = 1'b0;
    tick();
    for (int ie = 0; ie < 4; ie++) begin
      empty_ie = ie[0]; cpl_ie = ie[1];
      #1;
      chk("R11 irq empty=1 done=0", irq, ie[0] ? 1 : 0);
    end
    empty_ie = 1'b0; cpl_ie = 1'b0;
    data_bits(8'h11, 0);
    tick();
    tick();
    chk("R6 done after last frame", tx_done, 1);

    finish();
  end
endmodule